// File: doc/BRIEF.md
# Dual-Port I/O Peripheral with Interval Timer

This block hangs off an 8-bit processor bus and gives software two byte-wide bidirectional ports and one interval timer. Each port has an output data register and a direction register. A direction bit of 1 makes that pin an output. A read of a port returns the driven value on output bits and the sampled pin on input bits. On port B, bit 2 and bit 3 of every read are replaced by two external status lines, both inverted: a "speech ready" line and a "speech interrupt" line.

The timer takes an 8-bit start value and one of four prescale divisors. While it counts, a read returns the remaining count in prescale units. When the count runs out, flag bit 7 is set. The timer then keeps decrementing once per clock, so software can measure how late it came to service the timer. The interrupt output is the timer flag gated by an enable. The enable is loaded by the timer write, and it is loaded again by every timer-count read from address bit 3. A flag read returns the flag and clears it.

Top module: `io_timer_periph`

## Requirements
- R1: After synchronous reset, both direction registers and both data registers are 0x00, the flag and the interrupt enable are 0, the timer is idle, `irq` is 0 and `rdata` is 0x00.
- R2: A bus access with `addr[2]`=0 reaches the ports. `addr[1:0]` selects the target: 0 is port A data, 1 is port A direction, 2 is port B data and 3 is port B direction. A write updates the selected register, which drives `pa_out`/`pa_dir` or `pb_out`/`pb_dir`. A direction read returns the register.
- R3: A port data read returns, bit by bit, the data register where the direction bit is 1 and the input pin where it is 0.
- R4: On a port B data read, bit 2 is the inverse of `spk_ready` and bit 3 is the inverse of `spk_int`. Both replace the values that R3 would give.
- R5: A write with `addr[2]`=1 and `addr[4]`=1 loads the start value from `wdata`. It selects the divisor from `addr[1:0]` (0 gives 1, 1 gives 8, 2 gives 64, 3 gives 1024), sets the interrupt enable to `addr[3]`, clears the flag and enters counting. A write with `addr[2]`=1 and `addr[4]`=0 has no effect.
- R6: After a load of value N with divisor D, the count read is N for the first D clocks after the load edge and then falls by one every D clocks. On the (N+1)*D-th edge after the load, flag bit 7 is set, the timer enters post-count, and `irq` rises if the enable is 1.
- R7: In post-count the count starts at 0xFF. It then falls by one on every clock, wrapping from 0x00 to 0xFF, and a count read returns it.
- R8: A read with `addr[2]`=1 and `addr[0]`=1 returns the flag register: bit 7 is the timer flag and the other bits are 0. The same read clears the flag, so `irq` is 0 from the next cycle.
- R9: A read with `addr[2]`=1 and `addr[0]`=0 sets the interrupt enable to `addr[3]`. `irq` then follows at once from the existing flag.
- R10: A count read while the timer is idle returns 0x00.
- R11: Read data appears on `rdata` from the clock edge that samples the read. It holds its value on cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Bus access strobe, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 5 | Register and mode select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A output register |
| pa_dir | output | 8 | Port A direction register |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B output register |
| pb_dir | output | 8 | Port B direction register |
| spk_ready | input | 1 | Status line, inverted into port B bit 2 |
| spk_int | input | 1 | Status line, inverted into port B bit 3 |
| irq | output | 1 | Active-high interrupt |

## Verification
Every access takes one edge. Register writes, the flag clear, the enable latch and `rdata` all change on the edge that samples the access. The bench drives each access half a cycle before its edge and samples half a cycle after it. A count read returns the state left by the previous edge. For that reason the bench counts idle edges from the load edge and predicts each value from R6 and R7. Timer expiry is checked as a pair of samples: `irq` is low after edge (N+1)*D-1 and high after edge (N+1)*D. This is done for every divisor, which pins the expiry to a single cycle.

// File: rtl/io_timer_pkg.sv
package io_timer_pkg;

  typedef enum logic [1:0] {
    TMR_IDLE  = 2'd0,
    TMR_COUNT = 2'd1,
    TMR_POST  = 2'd2
  } tmr_state_t;

  localparam int PRE_W = 10;

  // prescale reload value (divisor minus one) for a 2-bit selector
  function automatic logic [PRE_W-1:0] pre_reload(input logic [1:0] sel);
    logic [PRE_W-1:0] r;
    case (sel)
      2'd0:    r = PRE_W'(0);
      2'd1:    r = PRE_W'(7);
      2'd2:    r = PRE_W'(63);
      default: r = PRE_W'(1023);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/io_port_unit.sv
module io_port_unit #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] OVR_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic              wr_dir,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] pin_in,
  input  logic [DATA_W-1:0] ovr_val,
  output logic [DATA_W-1:0] out_q,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] rd_val
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      if (wr_data) out_q <= wdata;
      if (wr_dir)  dir_q <= wdata;
    end
  end

  logic [DATA_W-1:0] mixed;

  // output bits where direction is 1, pin value elsewhere, then status override
  always_comb begin
    mixed  = (out_q & dir_q) | (pin_in & ~dir_q);
    rd_val = (mixed & ~OVR_MASK) | (ovr_val & OVR_MASK);
  end

endmodule

// File: rtl/io_interval_timer.sv
module io_interval_timer
  import io_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [1:0]       load_sel,
  input  logic             load_en,
  input  logic             cnt_rd,
  input  logic             rd_en_bit,
  input  logic             flag_rd,
  output logic [CNT_W-1:0] count_view,
  output logic [CNT_W-1:0] flag_byte,
  output logic             irq,
  output tmr_state_t       state_o,
  output logic [CNT_W-1:0] cnt_o
);

  tmr_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [1:0]       sel;
  logic             flag;
  logic             irq_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TMR_IDLE;
      cnt    <= '0;
      pre    <= '0;
      sel    <= 2'd0;
      flag   <= 1'b0;
      irq_en <= 1'b0;
    end else if (load) begin
      cnt    <= load_val;
      sel    <= load_sel;
      pre    <= pre_reload(load_sel);
      state  <= TMR_COUNT;
      flag   <= 1'b0;
      irq_en <= load_en;
    end else begin
      if (flag_rd) flag <= 1'b0;
      if (cnt_rd)  irq_en <= rd_en_bit;
      case (state)
        TMR_COUNT: begin
          if (pre == '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == '0) begin
              flag  <= 1'b1;
              state <= TMR_POST;
            end else begin
              pre <= pre_reload(sel);
            end
          end else begin
            pre <= pre - 1'b1;
          end
        end
        TMR_POST: cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  assign count_view = (state == TMR_IDLE) ? '0 : cnt;
  assign flag_byte  = {flag, {(CNT_W-1){1'b0}}};
  assign irq        = flag & irq_en;
  assign state_o    = state;
  assign cnt_o      = cnt;

endmodule

// File: rtl/io_timer_periph.sv
module io_timer_periph
  import io_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_dir,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_dir,
  input  logic              spk_ready,
  input  logic              spk_int,
  output logic              irq
);

  localparam int NPORT = 2;
  localparam logic [DATA_W-1:0] PB_MASK = DATA_W'(8'h0C);

  logic rd, wr, io_sel;
  assign rd     = cs & ~we;
  assign wr     = cs & we;
  assign io_sel = ~addr[2];

  logic [NPORT-1:0][DATA_W-1:0] pin_arr, out_arr, dir_arr, rd_arr;
  logic [DATA_W-1:0] pb_status;

  assign pin_arr[0] = pa_in;
  assign pin_arr[1] = pb_in;
  assign pb_status  = PB_MASK & {{(DATA_W-4){1'b0}}, ~spk_int, ~spk_ready, 2'b00};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [DATA_W-1:0] MASK = (p == 1) ? PB_MASK : '0;
    io_port_unit #(.DATA_W(DATA_W), .OVR_MASK(MASK)) u_port (
      .clk     (clk),
      .rst     (rst),
      .wr_data (wr && io_sel && addr[1:0] == 2'(2*p)),
      .wr_dir  (wr && io_sel && addr[1:0] == 2'(2*p+1)),
      .wdata   (wdata),
      .pin_in  (pin_arr[p]),
      .ovr_val ((p == 1) ? pb_status : '0),
      .out_q   (out_arr[p]),
      .dir_q   (dir_arr[p]),
      .rd_val  (rd_arr[p])
    );
  end

  assign pa_out = out_arr[0];
  assign pa_dir = dir_arr[0];
  assign pb_out = out_arr[1];
  assign pb_dir = dir_arr[1];

  logic [DATA_W-1:0] count_view, flag_byte;
  tmr_state_t        tmr_state;
  logic [DATA_W-1:0] tmr_cnt;

  io_interval_timer #(.CNT_W(DATA_W)) u_tmr (
    .clk        (clk),
    .rst        (rst),
    .load       (wr && addr[2] && addr[4]),
    .load_val   (wdata),
    .load_sel   (addr[1:0]),
    .load_en    (addr[3]),
    .cnt_rd     (rd && addr[2] && !addr[0]),
    .rd_en_bit  (addr[3]),
    .flag_rd    (rd && addr[2] && addr[0]),
    .count_view (count_view),
    .flag_byte  (flag_byte),
    .irq        (irq),
    .state_o    (tmr_state),
    .cnt_o      (tmr_cnt)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    if (io_sel) begin
      case (addr[1:0])
        2'd0:    rd_mux = rd_arr[0];
        2'd1:    rd_mux = dir_arr[0];
        2'd2:    rd_mux = rd_arr[1];
        default: rd_mux = dir_arr[1];
      endcase
    end else if (addr[0]) begin
      rd_mux = flag_byte;
    end else begin
      rd_mux = count_view;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

endmodule

// File: rtl/io_timer_periph_chk.sv
module io_timer_periph_chk
  import io_timer_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cs,
  input logic       we,
  input logic [4:0] addr,
  input logic [7:0] rdata,
  input logic [7:0] pa_in,
  input logic [7:0] pa_out,
  input logic [7:0] pa_dir,
  input logic       spk_ready,
  input logic       spk_int,
  input logic       irq,
  input tmr_state_t tmr_state,
  input logic [7:0] tmr_cnt
);

  assert_port_mix_R3: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && addr[2:0] == 3'b000) |=>
      rdata == (($past(pa_out) & $past(pa_dir)) | ($past(pa_in) & ~$past(pa_dir))));

  assert_status_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && addr[2:0] == 3'b010) |=>
      (rdata[2] == !$past(spk_ready) && rdata[3] == !$past(spk_int)));

  assert_load_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (cs && we && addr[2] && addr[4]) |=> (!irq && tmr_state == TMR_COUNT));

  assert_post_decrement_R7: assert property (@(posedge clk) disable iff (rst)
    (tmr_state == TMR_POST && !(cs && we && addr[2] && addr[4])) |=>
      tmr_cnt == $past(tmr_cnt) - 8'd1);

  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && addr[2] && addr[0] && tmr_state != TMR_COUNT) |=> !irq);

  assert_idle_read_R10: assert property (@(posedge clk) disable iff (rst)
    (cs && !we && addr[2] && !addr[0] && tmr_state == TMR_IDLE) |=> rdata == 8'h00);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(cs && !we) |=> $stable(rdata));

endmodule

bind io_timer_periph io_timer_periph_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs        (cs),
  .we        (we),
  .addr      (addr),
  .rdata     (rdata),
  .pa_in     (pa_in),
  .pa_out    (pa_out),
  .pa_dir    (pa_dir),
  .spk_ready (spk_ready),
  .spk_int   (spk_int),
  .irq       (irq),
  .tmr_state (tmr_state),
  .tmr_cnt   (tmr_cnt)
);

// File: tb/sim_io_timer_periph.sv
module sim_io_timer_periph;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, cs, we, spk_ready, spk_int, irq;
  logic [4:0] addr;
  logic [7:0] wdata, rdata, pa_in, pa_out, pa_dir, pb_in, pb_out, pb_dir;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  io_timer_periph u0 (
    .clk(clk), .rst(rst), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir),
    .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir),
    .spk_ready(spk_ready), .spk_int(spk_int), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    cs = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    cs = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    check("R1 rdata", rdata, 8'h00);
    check("R1 pa_out", pa_out, 8'h00);
    check("R1 pa_dir", pa_dir, 8'h00);
    check("R1 pb_out", pb_out, 8'h00);
    check("R1 pb_dir", pb_dir, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_ports;
    logic [7:0] d;
    bus_write(5'b00001, 8'hF0);
    bus_write(5'b00000, 8'hA5);
    pa_in = 8'h3C;
    check("R2 pa_dir", pa_dir, 8'hF0);
    check("R2 pa_out", pa_out, 8'hA5);
    bus_read(5'b00001, d);  check("R2 dir readback", d, 8'hF0);
    bus_read(5'b00000, d);  check("R3 port A mix", d, 8'hAC);
    bus_write(5'b00010, 8'h5A);
    check("R11 hold", rdata, 8'hAC);
    pb_in = 8'hFF; spk_ready = 1'b1; spk_int = 1'b0;
    bus_read(5'b00010, d);  check("R4 port B inputs", d, 8'hFB);
    bus_write(5'b00011, 8'hFF);
    bus_write(5'b00010, 8'h00);
    check("R2 pb_dir", pb_dir, 8'hFF);
    spk_ready = 1'b0; spk_int = 1'b1;
    bus_read(5'b00010, d);  check("R4 port B outputs", d, 8'h04);
    bus_read(5'b00011, d);  check("R2 pb dir readback", d, 8'hFF);
  endtask

  task automatic t_idle_read;
    logic [7:0] d;
    bus_read(5'b00100, d);  check("R10 idle count", d, 8'h00);
  endtask

  task automatic t_div1_post;
    logic [7:0] d;
    bus_write(5'b11100, 8'd5);
    idle(5);  check("R6 div1 before expiry", {7'd0, irq}, 8'h00);
    idle(1);  check("R6 div1 at expiry", {7'd0, irq}, 8'h01);
    bus_read(5'b01100, d);  check("R7 post first", d, 8'hFF);
    bus_read(5'b01100, d);  check("R7 post next", d, 8'hFE);
    bus_read(5'b00101, d);  check("R8 flag value", d, 8'h80);
    check("R8 irq cleared", {7'd0, irq}, 8'h00);
    bus_read(5'b00101, d);  check("R8 flag empty", d, 8'h00);
  endtask

  task automatic t_div8;
    logic [7:0] d;
    bus_write(5'b11101, 8'd3);
    idle(10);
    bus_read(5'b01100, d);  check("R6 div8 remaining", d, 8'd2);
    idle(20); check("R5 div8 before expiry", {7'd0, irq}, 8'h00);
    idle(1);  check("R5 div8 at expiry", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_div64;
    bus_write(5'b11110, 8'd1);
    idle(127); check("R5 div64 before expiry", {7'd0, irq}, 8'h00);
    idle(1);   check("R5 div64 at expiry", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_div1024;
    bus_write(5'b11111, 8'd0);
    idle(1023); check("R5 div1024 before expiry", {7'd0, irq}, 8'h00);
    idle(1);    check("R5 div1024 at expiry", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_enable_latch;
    logic [7:0] d;
    bus_write(5'b10100, 8'd2);
    idle(4);  check("R9 disabled irq", {7'd0, irq}, 8'h00);
    bus_read(5'b01100, d);
    check("R9 enable set", {7'd0, irq}, 8'h01);
    bus_read(5'b00100, d);
    check("R9 enable cleared", {7'd0, irq}, 8'h00);
    bus_read(5'b00101, d);  check("R8 flag while disabled", d, 8'h80);
  endtask

  task automatic t_ignored_write;
    logic [7:0] d;
    bus_write(5'b11100, 8'd100);
    bus_write(5'b01100, 8'd5);
    bus_read(5'b01100, d);  check("R5 ignored write", d, 8'd99);
  endtask

  initial begin
    rst = 1'b1; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    pa_in = '0; pb_in = '0; spk_ready = 1'b0; spk_int = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_ports;
    t_idle_read;
    t_div1_post;
    t_div8;
    t_div64;
    t_div1024;
    t_enable_latch;
    t_ignored_write;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule